// File: doc/BRIEF.md
# Dual Complex Add/Subtract Accumulator

This block is a two-channel add/subtract unit for complex arithmetic. One channel handles the real part and the other handles the imaginary part. Each channel has a 20-bit adder/subtractor, an accumulator register and an operand multiplexer. The multiplexer feeds the adder either fresh input data or that channel's own accumulator, so each channel works as a plain adder or as an accumulator. Two 16-bit input ports, A and B, are sign-extended to 20 bits. Each port has a holding register with an active-low load enable. The real channel can take its A data through an 8-cycle deskew delay line. This lines up data that skipped an upstream multiplier stage in butterfly or filter pipelines.

Both 20-bit results pass through one shared window selector onto the 16-bit outputs. The selector either keeps the upper part of the result and drops low bits, or moves the result up and fills the low bits with zeros. A registered flag goes high when either result does not fit the selected window or when either adder leaves its 20-bit range. Every control is registered before it takes effect. The block takes a new pair of operands on every clock and delivers a result pair on every clock.

Top module: `cplx_accum_pair`

## Requirements
- R1: A synchronous active-high reset clears the following state:
  - the input registers
  - the deskew line
  - the registered controls
  - both accumulators
  - `c_out`, `d_out` and `ovf`
- R2: The A register loads `a_in` on a rising edge only while `a_en_n` is 0, and otherwise keeps its value. The B register behaves the same way with `b_in` and `b_en_n`. Both inputs are 16-bit two's complement with equal bit weights, and each is sign-extended to 20 bits.
- R3: Each channel has its own 2-bit operation code, with X as the multiplexer operand:
  - 2'b00 gives X+Y
  - 2'b01 gives X−Y
  - 2'b10 gives X alone
  - 2'b11 gives Y−X

  Y is the B register for the real channel and the A register for the imaginary channel.
- R4: When `fb_sel` is 0, X is new data: the delay-select output for the real channel and the B register for the imaginary channel. When `fb_sel` is 1, each channel takes X from its own accumulator.
- R5: When `dly_sel` is 0, the real channel's new data is the A register. When `dly_sel` is 1, it is the A register value from exactly 8 clocks earlier. The deskew line shifts on every clock, whatever `dly_sel` is.
- R6: While the registered `acc_clr` is 1, both accumulators load zero instead of the adder result. The outputs still show that cycle's result.
- R7: For a registered scale value s from 0 to 4, each output is result bits [19−s : 4−s]. `c_out` carries the real channel and `d_out` carries the imaginary channel.
- R8: For s from 5 to 7, each output is result bits [19−s : 0] followed by s−4 zero bits at the bottom.
- R9: `ovf` goes high when either 20-bit result, read as signed, lies outside [−2^(19−s), 2^(19−s)−1].
- R10: `ovf` also goes high when either exact sum or difference does not fit 20 signed bits. In that case the accumulator keeps the wrapped 20-bit value.
- R11: Data and controls applied before rising edge k are reflected on `c_out`, `d_out` and `ovf` after edge k+1, with a new result on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A operand data |
| a_en_n | input | 1 | A register load enable, active low |
| b_in | input | 16 | B operand data |
| b_en_n | input | 1 | B register load enable, active low |
| op_re | input | 2 | Real channel operation code |
| op_im | input | 2 | Imaginary channel operation code |
| fb_sel | input | 1 | 1 = accumulator feedback as X on both channels |
| acc_clr | input | 1 | Clear both accumulators |
| dly_sel | input | 1 | 1 = real channel uses the 8-cycle delayed A data |
| scale | input | 3 | Output window select |
| c_out | output | 16 | Real result window |
| d_out | output | 16 | Imaginary result window |
| ovf | output | 1 | Window or adder overflow flag |

## Verification
The assertions take for granted that reset is held for at least one clock before checking starts, and that control codes are always driven to known values. The stimulus keeps to this: it holds reset for several cycles and never leaves a control undriven. The pass-no-overflow property relies on a pass result always fitting 20 bits, which holds because every X operand is either a sign-extended 16-bit value or a 20-bit accumulator. The sweep drives extreme values (0x7FFF, 0x8000, 0xFFFF) on every operation code and scale setting. Long feedback runs force real adder wrap-around, so both kinds of overflow are triggered on purpose and not only by chance.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int SCALE_W = 3;

  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_SUB_XY = 2'b01,
    OP_PASS   = 2'b10,
    OP_SUB_YX = 2'b11
  } op_e;

  typedef struct packed {
    op_e                op_re;
    op_e                op_im;
    logic               fb;
    logic               clr;
    logic               del;
    logic [SCALE_W-1:0] scale;
  } ctl_t;
endpackage

// File: rtl/cpa_deskew.sv
module cpa_deskew #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/cpa_lane.sv
module cpa_lane
  import cpa_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic             fb,
  input  logic             clr,
  input  logic [ACC_W-1:0] new_x,
  input  logic [ACC_W-1:0] y,
  output logic [ACC_W-1:0] res,
  output logic             add_ovf,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] x;
  logic [ACC_W:0]   xe, ye, full;

  assign x  = fb ? acc : new_x;
  assign xe = {x[ACC_W-1], x};
  assign ye = {y[ACC_W-1], y};

  always_comb begin
    unique case (op)
      OP_ADD:    full = xe + ye;
      OP_SUB_XY: full = xe - ye;
      OP_PASS:   full = xe;
      default:   full = ye - xe;
    endcase
  end

  assign res     = full[ACC_W-1:0];
  assign add_ovf = full[ACC_W] ^ full[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else            acc <= res;
  end
endmodule

// File: rtl/cpa_window.sv
module cpa_window #(
  parameter int ACC_W   = 20,
  parameter int OUT_W   = 16,
  parameter int SCALE_W = 3
) (
  input  logic [ACC_W-1:0]   res,
  input  logic [SCALE_W-1:0] scale,
  output logic [OUT_W-1:0]   win,
  output logic               misfit
);
  localparam int EXT_W = ACC_W + OUT_W;

  logic [EXT_W-1:0]        ext;
  logic [ACC_W-1:0]        up;
  logic signed [ACC_W-1:0] back;

  assign ext    = {res, {OUT_W{1'b0}}} << scale;
  assign win    = ext[EXT_W-1 -: OUT_W];
  assign up     = res << scale;
  assign back   = $signed(up) >>> scale;
  assign misfit = (back != $signed(res));
endmodule

// File: rtl/cplx_accum_pair.sv
module cplx_accum_pair
  import cpa_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 20,
  parameter int DLY    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  a_in,
  input  logic               a_en_n,
  input  logic [DATA_W-1:0]  b_in,
  input  logic               b_en_n,
  input  logic [1:0]         op_re,
  input  logic [1:0]         op_im,
  input  logic               fb_sel,
  input  logic               acc_clr,
  input  logic               dly_sel,
  input  logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  c_out,
  output logic [DATA_W-1:0]  d_out,
  output logic               ovf
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [DATA_W-1:0] a_q, b_q, a_dly;
  ctl_t              ctl_q;
  logic [ACC_W-1:0]  a_x, b_x, d_x, x_re_new;
  logic [ACC_W-1:0]  res_re, res_im, acc_re, acc_im;
  logic              aov_re, aov_im, mis_re, mis_im;
  logic [DATA_W-1:0] win_re, win_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      if (!a_en_n) a_q <= a_in;
      if (!b_en_n) b_q <= b_in;
      ctl_q <= '{op_re: op_e'(op_re), op_im: op_e'(op_im), fb: fb_sel,
                 clr: acc_clr, del: dly_sel, scale: scale};
    end
  end

  cpa_deskew #(.W(DATA_W), .DEPTH(DLY)) u_deskew (
    .clk(clk), .rst(rst), .d(a_q), .q(a_dly)
  );

  assign a_x      = {{EXT_W{a_q[DATA_W-1]}}, a_q};
  assign b_x      = {{EXT_W{b_q[DATA_W-1]}}, b_q};
  assign d_x      = {{EXT_W{a_dly[DATA_W-1]}}, a_dly};
  assign x_re_new = ctl_q.del ? d_x : a_x;

  cpa_lane #(.ACC_W(ACC_W)) u_lane_re (
    .clk(clk), .rst(rst), .op(ctl_q.op_re), .fb(ctl_q.fb), .clr(ctl_q.clr),
    .new_x(x_re_new), .y(b_x), .res(res_re), .add_ovf(aov_re), .acc(acc_re)
  );

  cpa_lane #(.ACC_W(ACC_W)) u_lane_im (
    .clk(clk), .rst(rst), .op(ctl_q.op_im), .fb(ctl_q.fb), .clr(ctl_q.clr),
    .new_x(b_x), .y(a_x), .res(res_im), .add_ovf(aov_im), .acc(acc_im)
  );

  cpa_window #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SCALE_W(SCALE_W)) u_win_re (
    .res(res_re), .scale(ctl_q.scale), .win(win_re), .misfit(mis_re)
  );

  cpa_window #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SCALE_W(SCALE_W)) u_win_im (
    .res(res_im), .scale(ctl_q.scale), .win(win_im), .misfit(mis_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_out <= '0;
      d_out <= '0;
      ovf   <= 1'b0;
    end else begin
      c_out <= win_re;
      d_out <= win_im;
      ovf   <= aov_re | aov_im | mis_re | mis_im;
    end
  end
endmodule

// File: rtl/cpa_checker.sv
module cpa_checker #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] a_in,
  input logic              a_en_n,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_in,
  input logic              b_en_n,
  input logic [DATA_W-1:0] b_q,
  input logic              clr_q,
  input logic [1:0]        op_re_q,
  input logic [1:0]        op_im_q,
  input logic [2:0]        scale_q,
  input logic [ACC_W-1:0]  acc_re,
  input logic [ACC_W-1:0]  acc_im,
  input logic [DATA_W-1:0] c_out,
  input logic [DATA_W-1:0] d_out,
  input logic              ovf
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (c_out == '0 && d_out == '0 && !ovf && acc_re == '0 && acc_im == '0)); // R1

  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    a_en_n |=> $stable(a_q)); // R2

  AST_A_LOAD: assert property (@(posedge clk) disable iff (rst)
    !a_en_n |=> (a_q == $past(a_in))); // R2

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    b_en_n |=> $stable(b_q)); // R2

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (acc_re == '0 && acc_im == '0)); // R6

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (scale_q == 3'd7) |=> (c_out[2:0] == 3'b000 && d_out[2:0] == 3'b000)); // R8

  AST_PASS_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (op_re_q == 2'b10 && op_im_q == 2'b10 && scale_q == 3'd0) |=> !ovf); // R10
endmodule

bind cplx_accum_pair cpa_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .a_en_n(a_en_n), .a_q(a_q),
  .b_in(b_in), .b_en_n(b_en_n), .b_q(b_q), .clr_q(ctl_q.clr),
  .op_re_q(ctl_q.op_re), .op_im_q(ctl_q.op_im), .scale_q(ctl_q.scale),
  .acc_re(acc_re), .acc_im(acc_im), .c_out(c_out), .d_out(d_out), .ovf(ovf)
);

// File: tb/tb_cplx_accum_pair.sv
`timescale 1ns/1ps
module tb_cplx_accum_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0, b_in = '0;
  logic        a_en_n = 1'b1, b_en_n = 1'b1;
  logic [1:0]  op_re = '0, op_im = '0;
  logic        fb_sel = 1'b0, acc_clr = 1'b0, dly_sel = 1'b0;
  logic [2:0]  scale = '0;
  logic [15:0] c_out, d_out;
  logic        ovf;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cplx_accum_pair dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_en_n(a_en_n), .b_in(b_in),
    .b_en_n(b_en_n), .op_re(op_re), .op_im(op_im), .fb_sel(fb_sel),
    .acc_clr(acc_clr), .dly_sel(dly_sel), .scale(scale),
    .c_out(c_out), .d_out(d_out), .ovf(ovf)
  );

  // Reference model state, kept as plain integers.
  longint ma, mb, mdly [8], macc_re, macc_im;
  longint xr, xi, er, ei, wr, wi;
  int q_op_re, q_op_im, q_s;
  bit q_fb, q_clr, q_del;
  logic [15:0] exp_c, exp_d;
  bit exp_ovf;

  function automatic longint alu(int op, longint x, longint y);
    case (op)
      0: return x + y;
      1: return x - y;
      2: return x;
      default: return y - x;
    endcase
  endfunction

  function automatic longint wrap20(longint v);
    longint t = v & 64'hFFFFF;
    if (t >= (64'sd1 << 19)) t = t - (64'sd1 << 20);
    return t;
  endfunction

  function automatic logic [15:0] win(longint w, int s);
    longint t;
    if (s <= 4) t = w >>> (4 - s);
    else        t = w <<  (s - 4);
    return t[15:0];
  endfunction

  function automatic bit fits(longint w, int s);
    longint lim = 64'sd1 << (19 - s);
    return (w >= -lim) && (w < lim);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ma = 0; mb = 0; macc_re = 0; macc_im = 0;
      for (int i = 0; i < 8; i++) mdly[i] = 0;
      q_op_re = 0; q_op_im = 0; q_s = 0; q_fb = 0; q_clr = 0; q_del = 0;
      exp_c = '0; exp_d = '0; exp_ovf = 0;
    end else begin
      xr = q_fb ? macc_re : (q_del ? mdly[7] : ma);
      xi = q_fb ? macc_im : mb;
      er = alu(q_op_re, xr, mb);
      ei = alu(q_op_im, xi, ma);
      wr = wrap20(er);
      wi = wrap20(ei);
      exp_c   = win(wr, q_s);
      exp_d   = win(wi, q_s);
      exp_ovf = (er != wr) || (ei != wi) || !fits(wr, q_s) || !fits(wi, q_s);
      macc_re = q_clr ? 0 : wr;
      macc_im = q_clr ? 0 : wi;
      for (int i = 7; i > 0; i--) mdly[i] = mdly[i-1];
      mdly[0] = ma;
      if (!a_en_n) ma = longint'($signed(a_in));
      if (!b_en_n) mb = longint'($signed(b_in));
      q_op_re = op_re; q_op_im = op_im; q_s = scale;
      q_fb = fb_sel; q_clr = acc_clr; q_del = dly_sel;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tcd, string tov);
    @(posedge clk);
    @(negedge clk);
    chk(tcd, "c_out", c_out, exp_c);
    chk(tcd, "d_out", d_out, exp_d);
    chk(tov, "ovf", {15'd0, ovf}, {15'd0, exp_ovf});
  endtask

  task automatic drive(logic [15:0] a, logic [15:0] b, bit ae, bit be,
                       int ore, int oim, bit fb, bit clr, bit del, int s);
    a_in = a; b_in = b; a_en_n = ae; b_en_n = be;
    op_re = ore[1:0]; op_im = oim[1:0]; fb_sel = fb; acc_clr = clr;
    dly_sel = del; scale = s[2:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa [6];
    logic [15:0] pb [6];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1", "c_out", c_out, 16'h0);
    chk("R1", "d_out", d_out, 16'h0);
    chk("R1", "ovf", {15'd0, ovf}, 16'h0);

    // R2: load, then hold with enables high
    drive(16'h1234, 16'h0F0F, 0, 0, 2, 2, 0, 0, 0, 0);
    tick("R2", "R2"); tick("R2", "R2");
    drive(16'h7777, 16'h8888, 1, 1, 2, 2, 0, 0, 0, 0);
    repeat (3) tick("R2", "R2");
    drive(16'h5555, 16'h8888, 0, 1, 0, 0, 0, 0, 0, 0);
    repeat (3) tick("R2", "R2");

    // R3 R7 R8 R9: sweep of scale, both opcodes, extreme data
    pa = '{16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF, 16'h0000, 16'h4000};
    pb = '{16'h7FFF, 16'h7FFF, 16'h8000, 16'h0001, 16'h8000, 16'hC000};
    for (int s = 0; s < 8; s++)
      for (int orv = 0; orv < 4; orv++)
        for (int oiv = 0; oiv < 4; oiv++)
          for (int p = 0; p < 8; p++) begin
            if (p < 6) drive(pa[p], pb[p], 0, 0, orv, oiv, 0, 0, 0, s);
            else       drive($urandom, $urandom, 0, 0, orv, oiv, 0, 0, 0, s);
            tick(s < 5 ? "R3 R7" : "R3 R8", "R9");
          end

    // R4 R10: feedback accumulation running into adder wrap
    drive(16'h7FFF, 16'h7FFF, 0, 0, 0, 0, 0, 1, 0, 0);
    tick("R4", "R10");
    drive(16'h7FFF, 16'h7FFF, 1, 1, 0, 3, 1, 0, 0, 0);
    repeat (40) tick("R4", "R10");
    drive(16'h8000, 16'h8000, 0, 0, 0, 0, 1, 0, 0, 2);
    repeat (40) tick("R4", "R10");

    // R5: deskew path, including toggling the delay select
    for (int i = 0; i < 40; i++) begin
      drive(16'(i * 16'h0111), 16'h0003, 0, 0, 2, 0, 0, 0, (i % 16) < 11, 0);
      tick("R5", "R5");
    end

    // R6: clear pulses during accumulation
    for (int i = 0; i < 24; i++) begin
      drive(16'h0100, 16'hFF00, 0, 0, 0, 1, 1, (i % 5) == 4, 0, 1);
      tick("R6", "R6");
    end

    // R11: unconstrained back-to-back stream
    for (int i = 0; i < 2000; i++) begin
      drive($urandom, $urandom, 1'($urandom), 1'($urandom), $urandom % 4,
            $urandom % 4, 1'($urandom), ($urandom % 7) == 0, 1'($urandom),
            $urandom % 8);
      tick("R11", "R11");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule